// File: doc/BRIEF.md
# Dual-Clock FIFO with Mode-Selectable Read Flags

This block is a first-in first-out buffer between two unrelated clock domains. Words enter on a write port clocked by `wrClk` and leave through a registered read port clocked by `rdClk`. Each pointer is Gray-coded and passed into the other domain through a two-stage synchronizer. Every status flag is then derived in the domain that uses it. The write side reports whether a slot is free and whether the buffer is almost full. The read side reports whether a word can be taken and whether the buffer holds more than a programmable low-water level.

A static mode input chooses how the read port behaves. In standard mode, a word is copied into the output register only when a read is requested. In fall-through mode, the oldest word moves into the output register by itself, and the flag then means "a valid word is on `rdData`". In both modes, all occupancy flags count only the words still held in the RAM. A word that has already been moved into the output register no longer counts.

The thresholds are plain inputs: `aeLevel` (X) and `afLevel` (Y). `DEPTH` must be a power of two and at least 4. The mode and the thresholds are meant to change only while the buffer is idle or held in reset.

Top module: `xclk_fifo`

## Requirements
- R1: While `rstN` is low and after it is released, `rdAvail` and `rdNotAlmostEmpty` are 0, and `wrNotFull` and `wrNotAlmostFull` are 1.
- R2: Words accepted on the write port leave the read port in the same order, with no loss and no duplication, across any number of pointer wraps.
- R3: In standard mode (`fwftMode`=0), after a write into an empty buffer, `rdAvail` rises on the second `rdClk` rising edge. `rdData` changes only on the edge of an accepted read (`rdEn`=1 with `rdAvail`=1), and then shows the word that was read.
- R4: In fall-through mode (`fwftMode`=1), after a write into an empty buffer, the word appears on `rdData` on the third `rdClk` rising edge, and `rdAvail` rises on that same edge.
- R5: A read requested while `rdAvail` is 0 is ignored, and `rdData` keeps its previous word.
- R6: `wrNotFull` is 0 when the RAM holds `DEPTH` words, and writes are then ignored. After a read frees a slot, `wrNotFull` returns to 1 on the second `wrClk` rising edge.
- R7: `rdNotAlmostEmpty` is 1 exactly when the RAM holds more than `aeLevel` words. After the write that brings the count to `aeLevel`+1, it rises on the second `rdClk` rising edge.
- R8: `wrNotAlmostFull` is 0 exactly when the RAM holds at least `DEPTH`−`afLevel` words.
- R9: In fall-through mode, the word held in the output register is not counted by any flag, so the buffer accepts `DEPTH`+1 words in total.
- R10: In fall-through mode, while `rdAvail` is 1 and no read is requested, `rdAvail` stays 1 and `rdData` stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| rdClk | input | 1 | Read-domain clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| fwftMode | input | 1 | 1 = fall-through read port, 0 = standard read port |
| aeLevel | input | $clog2(DEPTH)+1 | Almost-empty threshold X |
| afLevel | input | $clog2(DEPTH)+1 | Almost-full threshold Y, 1 to DEPTH−1 |
| wrEn | input | 1 | Write request |
| wrData | input | WIDTH | Write data |
| rdEn | input | 1 | Read request |
| rdData | output | WIDTH | Output register |
| wrNotFull | output | 1 | Free slot available (write domain) |
| wrNotAlmostFull | output | 1 | Occupancy below DEPTH−Y (write domain) |
| rdAvail | output | 1 | Standard: RAM not empty; fall-through: rdData valid |
| rdNotAlmostEmpty | output | 1 | Occupancy above X (read domain) |

## Verification
The bench builds the block with `DEPTH`=8 and `WIDTH`=8. With these values, both the full and the almost-full boundaries are reached within a few writes, and the pointers wrap many times in each random pass. The two clocks have periods of 10 and 12 time units, so their rising edges never coincide. This keeps the two-edge and three-edge latencies countable as exact edge numbers. The random passes use write-heavy, read-heavy and balanced rates in both modes, with new thresholds chosen for each pass.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

  typedef struct packed {
    logic wrStb;    // write-domain: store wrData at wrAddr
    logic loadStb;  // read-domain: copy RAM word at rdAddr into output register
  } fifo_strobe_t;

  function automatic logic [31:0] binToGray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] grayToBin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : gStage
    if (i == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[0] <= '0;
        else       stage[0] <= d;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[i] <= '0;
        else       stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/xclk_fifo_ctrl.sv
module xclk_fifo_ctrl
  import xclk_fifo_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          fwftMode,
  input  logic [PW-1:0] aeLevel,
  input  logic [PW-1:0] afLevel,
  input  logic          wrEn,
  input  logic          rdEn,
  output fifo_strobe_t  stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          wrNotFull,
  output logic          wrNotAlmostFull,
  output logic          rdAvail,
  output logic          rdNotAlmostEmpty
);
  // ---------------- write domain ----------------
  logic [PW-1:0] wBin, wGray, wBinNext, rGrayW, rBinW, wFill;
  logic          fullNow, wrAccept;

  assign wBinNext = wBin + PW'(1);
  assign wrAccept = wrEn && !fullNow;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wBin  <= '0;
      wGray <= '0;
    end else if (wrAccept) begin
      wBin  <= wBinNext;
      wGray <= PW'(binToGray(32'(wBinNext)));
    end
  end

  xclk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) uSyncR2W (
    .clk(wrClk), .rstN(rstN), .d(rGray), .q(rGrayW)
  );

  assign rBinW   = PW'(grayToBin(32'(rGrayW)));
  assign wFill   = wBin - rBinW;
  assign fullNow = (wGray == {~rGrayW[PW-1:PW-2], rGrayW[PW-3:0]});

  assign wrNotFull       = !fullNow;
  assign wrNotAlmostFull = ({1'b0, wFill} + {1'b0, afLevel}) < (PW+1)'(DEPTH);

  // ---------------- read domain ----------------
  logic [PW-1:0] rBin, rGray, rBinNext, wGrayR, wBinR, rFill;
  logic          memAvail, outValid, loadNow;

  xclk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) uSyncW2R (
    .clk(rdClk), .rstN(rstN), .d(wGray), .q(wGrayR)
  );

  assign wBinR    = PW'(grayToBin(32'(wGrayR)));
  assign rFill    = wBinR - rBin;
  assign memAvail = (wGrayR != rGray);
  assign rBinNext = rBin + PW'(1);

  // fall-through refills the output register whenever it is empty or being consumed
  assign loadNow = fwftMode ? (memAvail && (!outValid || rdEn))
                            : (memAvail && rdEn);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rBin  <= '0;
      rGray <= '0;
    end else if (loadNow) begin
      rBin  <= rBinNext;
      rGray <= PW'(binToGray(32'(rBinNext)));
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)          outValid <= 1'b0;
    else if (!fwftMode) outValid <= 1'b0;
    else if (loadNow)   outValid <= 1'b1;
    else if (rdEn)      outValid <= 1'b0;
  end

  assign rdAvail          = fwftMode ? outValid : memAvail;
  assign rdNotAlmostEmpty = rFill > aeLevel;

  // ---------------- strobes to datapath ----------------
  assign stb.wrStb   = wrAccept;
  assign stb.loadStb = loadNow;
  assign wrAddr      = wBin[AW-1:0];
  assign rdAddr      = rBin[AW-1:0];
endmodule

// File: rtl/xclk_fifo_mem.sv
module xclk_fifo_mem
  import xclk_fifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  fifo_strobe_t     stb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] ram [DEPTH];

  always_ff @(posedge wrClk)
    if (stb.wrStb) ram[wrAddr] <= wrData;

  always_ff @(posedge rdClk or negedge rstN)
    if (!rstN)            rdData <= '0;
    else if (stb.loadStb) rdData <= ram[rdAddr];
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             fwftMode,
  input  logic [PW-1:0]    aeLevel,
  input  logic [PW-1:0]    afLevel,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             wrNotFull,
  output logic             wrNotAlmostFull,
  output logic             rdAvail,
  output logic             rdNotAlmostEmpty
);
  fifo_strobe_t  stb;
  logic [AW-1:0] wrAddr, rdAddr;

  xclk_fifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode),
    .aeLevel(aeLevel), .afLevel(afLevel), .wrEn(wrEn), .rdEn(rdEn),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrNotFull(wrNotFull), .wrNotAlmostFull(wrNotAlmostFull),
    .rdAvail(rdAvail), .rdNotAlmostEmpty(rdNotAlmostEmpty)
  );

  xclk_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uMem (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int WIDTH = 32
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             rstN,
  input logic             fwftMode,
  input logic             rdEn,
  input logic [WIDTH-1:0] rdData,
  input logic             rdAvail,
  input logic             rdNotAlmostEmpty,
  input logic             wrNotFull,
  input logic             wrNotAlmostFull
);
  // R10: fall-through output held while nobody reads
  assert_fwft_hold_R10: assert property (@(posedge rdClk) disable iff (!rstN)
    (fwftMode && rdAvail && !rdEn) |=> (rdAvail && $stable(rdData)));

  // R5: standard-mode read with nothing available leaves the output register alone
  assert_ignored_read_R5: assert property (@(posedge rdClk) disable iff (!rstN)
    (!fwftMode && rdEn && !rdAvail) |=> $stable(rdData));

  // R8: a full RAM is always past the almost-full mark
  assert_full_is_almost_full_R8: assert property (@(posedge wrClk) disable iff (!rstN)
    !wrNotFull |-> !wrNotAlmostFull);

  // R7: in standard mode, above the low-water level implies data available
  assert_above_level_has_data_R7: assert property (@(posedge rdClk) disable iff (!rstN)
    (!fwftMode && rdNotAlmostEmpty) |-> rdAvail);
endmodule

bind xclk_fifo xclk_fifo_chk #(.WIDTH(WIDTH)) uChk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode),
  .rdEn(rdEn), .rdData(rdData), .rdAvail(rdAvail),
  .rdNotAlmostEmpty(rdNotAlmostEmpty), .wrNotFull(wrNotFull),
  .wrNotAlmostFull(wrNotAlmostFull)
);

// File: tb/xclk_fifo_tb.sv
module xclk_fifo_tb;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 12;
  localparam int WIDTH = 8;
  localparam int DEPTH = 8;
  localparam int PW = $clog2(DEPTH) + 1;

  logic wrClk = 0, rdClk = 0, rstN = 0, fwftMode = 0;
  logic [PW-1:0] aeLevel = 0, afLevel = 1;
  logic wrEn = 0, rdEn = 0;
  logic [WIDTH-1:0] wrData = 0;
  logic [WIDTH-1:0] rdData;
  logic wrNotFull, wrNotAlmostFull, rdAvail, rdNotAlmostEmpty;

  always #(WR_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2) rdClk = ~rdClk;

  xclk_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode),
    .aeLevel(aeLevel), .afLevel(afLevel), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .wrNotFull(wrNotFull),
    .wrNotAlmostFull(wrNotAlmostFull), .rdAvail(rdAvail),
    .rdNotAlmostEmpty(rdNotAlmostEmpty)
  );

  int nVec = 0, nBad = 0;
  int wrEdges = 0, rdEdges = 0;
  int startR = 0, startW = 0;
  bit done = 0;
  logic [WIDTH-1:0] q[$];

  always @(posedge wrClk) wrEdges++;
  always @(posedge rdClk) rdEdges++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int memWords();
    if (fwftMode) return (q.size() > 0) ? q.size() - 1 : 0;
    return q.size();
  endfunction

  task automatic doReset(input bit m);
    rstN = 0; wrEn = 0; rdEn = 0; fwftMode = m;
    q.delete();
    #(3*RD_PERIOD);
    check(rdAvail == 0 && rdNotAlmostEmpty == 0, "R1 read flags in reset",
          {rdAvail, rdNotAlmostEmpty}, 0);
    check(wrNotFull == 1 && wrNotAlmostFull == 1, "R1 write flags in reset",
          {wrNotFull, wrNotAlmostFull}, 3);
    rstN = 1;
    repeat (3) @(negedge rdClk);
  endtask

  task automatic wrWord(input logic [WIDTH-1:0] d, output bit acc);
    @(negedge wrClk);
    wrData = d; wrEn = 1; acc = wrNotFull;
    if (acc) q.push_back(d);
    @(posedge wrClk);
    startR = rdEdges;
    #1 wrEn = 0;
  endtask

  // standard-mode read with data check
  task automatic rdWord(output bit acc);
    logic [WIDTH-1:0] exp;
    exp = 0;
    @(negedge rdClk);
    acc = rdAvail; rdEn = 1;
    if (acc) exp = q.pop_front();
    @(posedge rdClk);
    startW = wrEdges;
    #1 rdEn = 0;
    if (acc) begin
      @(negedge rdClk);
      check(rdData == exp, "R2 read order", rdData, exp);
    end
  endtask

  task automatic fwftRead();
    @(negedge rdClk);
    rdEn = 1;
    if (rdAvail) void'(q.pop_front());
    @(posedge rdClk);
    #1 rdEn = 0;
  endtask

  task automatic quiesce();
    repeat (10) @(negedge rdClk);
  endtask

  task automatic quietCheck();
    int m;
    quiesce();
    m = memWords();
    check(rdAvail == (q.size() > 0), "R3/R4 availability at rest", rdAvail, q.size() > 0);
    check(rdNotAlmostEmpty == (m > int'(aeLevel)), "R7 low-water flag", rdNotAlmostEmpty, m > int'(aeLevel));
    @(negedge wrClk);
    check(wrNotFull == (m < DEPTH), "R6 free-slot flag", wrNotFull, m < DEPTH);
    check(wrNotAlmostFull == (m + int'(afLevel) < DEPTH), "R8 high-water flag",
          wrNotAlmostFull, m + int'(afLevel) < DEPTH);
  endtask

  task automatic writer(input int pct);
    for (int i = 0; i < 250; i++) begin
      @(negedge wrClk);
      wrEn = (($urandom % 100) < pct);
      wrData = WIDTH'($urandom);
      if (wrEn && wrNotFull) q.push_back(wrData);
    end
    @(negedge wrClk) wrEn = 0;
  endtask

  task automatic reader(input int pct);
    bit pending = 0;
    logic [WIDTH-1:0] pendVal = 0;
    for (int i = 0; i < 250; i++) begin
      @(negedge rdClk);
      if (pending) begin
        check(rdData == pendVal, "R2 random read order", rdData, pendVal);
        pending = 0;
      end
      if (fwftMode && rdAvail) begin
        if (q.size() == 0) check(0, "R10 fall-through word present", 0, 1);
        else check(rdData == q[0], "R10 fall-through word", rdData, q[0]);
      end
      rdEn = (($urandom % 100) < pct);
      if (rdEn && rdAvail) begin
        if (fwftMode) void'(q.pop_front());
        else begin pendVal = q.pop_front(); pending = 1; end
      end
    end
    @(negedge rdClk);
    rdEn = 0;
    if (pending) check(rdData == pendVal, "R2 random read order", rdData, pendVal);
  endtask

  initial begin
    #(WR_PERIOD * 150000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    bit acc;
    int n;
    logic [WIDTH-1:0] prev;
    void'($urandom(32'd20240611));

    // ---------- standard mode directed ----------
    aeLevel = 2; afLevel = 2;
    doReset(0);
    check(rdAvail == 0 && rdNotAlmostEmpty == 0 && wrNotFull == 1 && wrNotAlmostFull == 1,
          "R1 flags after reset", {rdAvail, rdNotAlmostEmpty, wrNotFull, wrNotAlmostFull}, 3);

    wrWord(8'hA5, acc);
    n = 0;
    while (!rdAvail && n < 20) begin @(negedge rdClk); n++; end
    check(rdEdges - startR == 2, "R3 empty flag latency", rdEdges - startR, 2);
    check(rdData == 0, "R3 no move before read", rdData, 0);
    rdWord(acc);
    check(acc == 1 && rdData == 8'hA5, "R3 word after read", rdData, 8'hA5);

    quiesce();
    prev = rdData;
    rdWord(acc);
    @(negedge rdClk);
    check(acc == 0 && rdData == prev, "R5 ignored read holds output", rdData, prev);

    // low-water latency, X = 2
    wrWord(8'h11, acc); wrWord(8'h12, acc);
    quiesce();
    check(rdNotAlmostEmpty == 0, "R7 at level X stays low", rdNotAlmostEmpty, 0);
    wrWord(8'h13, acc);
    n = 0;
    while (!rdNotAlmostEmpty && n < 20) begin @(negedge rdClk); n++; end
    check(rdEdges - startR == 2, "R7 low-water latency", rdEdges - startR, 2);
    for (int i = 0; i < 3; i++) rdWord(acc);

    // full boundary
    quiesce();
    for (int i = 0; i < DEPTH; i++) wrWord(WIDTH'(8'h20 + i), acc);
    quiesce();
    @(negedge wrClk);
    check(wrNotFull == 0, "R6 full after DEPTH words", wrNotFull, 0);
    check(wrNotAlmostFull == 0, "R8 almost full at DEPTH", wrNotAlmostFull, 0);
    wrWord(8'hEE, acc);
    rdWord(acc);
    n = 0;
    while (!wrNotFull && n < 20) begin @(negedge wrClk); n++; end
    check(wrEdges - startW == 2, "R6 free-slot latency", wrEdges - startW, 2);
    for (int i = 0; i < DEPTH - 1; i++) rdWord(acc);
    quiesce();
    check(rdAvail == 0, "R6 write while full was ignored", rdAvail, 0);
    check(rdData == 8'h27, "R6 last word drained", rdData, 8'h27);

    // ---------- fall-through mode directed ----------
    aeLevel = 0; afLevel = 1;
    doReset(1);
    wrWord(8'h3C, acc);
    n = 0;
    while (!rdAvail && n < 20) begin @(negedge rdClk); n++; end
    check(rdEdges - startR == 3, "R4 output-ready latency", rdEdges - startR, 3);
    check(rdData == 8'h3C, "R4 word falls through", rdData, 8'h3C);
    quiesce();
    check(rdNotAlmostEmpty == 0, "R9 output word not counted", rdNotAlmostEmpty, 0);
    wrWord(8'h4D, acc);
    quiesce();
    check(rdNotAlmostEmpty == 1, "R9 one word in RAM", rdNotAlmostEmpty, 1);
    fwftRead();
    @(negedge rdClk);
    check(rdAvail == 1 && rdData == 8'h4D, "R4 next word follows read", rdData, 8'h4D);
    fwftRead();
    quiesce();
    check(rdAvail == 0 && rdData == 8'h4D, "R5 output kept when drained", rdData, 8'h4D);
    for (int i = 0; i < DEPTH + 1; i++) wrWord(WIDTH'(8'h60 + i), acc);
    quiesce();
    @(negedge wrClk);
    check(wrNotFull == 0 && q.size() == DEPTH + 1, "R9 capacity DEPTH+1", q.size(), DEPTH + 1);

    // ---------- random passes ----------
    for (int m = 0; m < 2; m++) begin
      doReset(m[0]);
      for (int p = 0; p < 4; p++) begin
        int wp, rp;
        aeLevel = PW'($urandom % DEPTH);
        afLevel = PW'(1 + ($urandom % (DEPTH - 1)));
        case (p)
          0: begin wp = 85; rp = 30; end
          1: begin wp = 30; rp = 85; end
          2: begin wp = 60; rp = 60; end
          default: begin wp = 50; rp = 45; end
        endcase
        fork
          writer(wp);
          reader(rp);
        join
        quietCheck();
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule